// File: doc/BRIEF.md
# CPRI Frame Position Counter

This block keeps the word-level timing position of a CPRI link on a 32-bit datapath. It holds four nested counts: the word inside the current basic frame, the basic frame inside the hyperframe, the hyperframe inside the 10 ms radio frame, and a 12-bit radio frame number. It also flags the first word of every hyperframe and of every radio frame. Framing and insertion logic read these counts to find out which slot of the outgoing or incoming frame the current clock cycle carries.

A rate code sets the number of 32-bit words per basic frame to suit the line rate. A new code is picked up only at a basic-frame boundary, so no basic frame is ever cut short. A master node can realign the timing with a sync input. On a rising edge of that input, all the position counts restart from zero, and the radio frame number is loaded from a reload input.

Top module: `frame_pos_counter`

## Requirements
- R1: While rst_ni is low, the word, basic-frame and hyperframe indexes and the radio frame number are all 0. Rate code 0 is the active rate until the first basic-frame boundary after reset.
- R2: The word index counts up by one on each clock and returns to 0 after its last value. The last value depends on the active rate code: 3, 7, 15, 19, 31, 39, 63, 63, 79 for codes 0 to 8. Codes 9 to 15 behave as code 0.
- R3: A new value on rate_sel_i becomes the active rate only when the word index wraps to 0, or when a resync takes place.
- R4: The basic-frame index advances by one when the word index wraps. It counts 0 to 255 and then returns to 0.
- R5: The hyperframe index advances by one when the basic-frame index wraps. It counts 0 to 149 and then returns to 0.
- R6: The radio frame number advances by one when the hyperframe index wraps. It returns from 4095 to 0.
- R7: hf_pulse_o is high exactly on the cycles where the word index and the basic-frame index are both 0. It is therefore a one-cycle pulse.
- R8: rf_pulse_o is high exactly on the cycles where the word, basic-frame and hyperframe indexes are all 0.
- R9: A rising edge on sync_i is a change from 0 to 1 against the value on the previous clock. One clock after that edge, the word, basic-frame and hyperframe indexes read 0, both pulses are high, and the radio frame number equals reload_i as sampled on the edge cycle.
- R10: Holding sync_i high causes no further resync, and counting continues. reload_i has no effect unless a rising edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 4 | Line-rate code that selects the number of words per basic frame |
| sync_i | input | 1 | Realignment request; acts on its rising edge |
| reload_i | input | 12 | Radio frame number loaded on a resync |
| word_idx_o | output | 7 | Word index inside the basic frame |
| bf_idx_o | output | 8 | Basic-frame index inside the hyperframe |
| hf_idx_o | output | 8 | Hyperframe index inside the radio frame |
| rf_num_o | output | 12 | Radio frame number |
| hf_pulse_o | output | 1 | Marks the first word of a hyperframe |
| rf_pulse_o | output | 1 | Marks the first word of a radio frame |

## Verification
The bound checker watches these properties on every cycle:
- the word and hyperframe indexes stay inside their ranges;
- the basic-frame index and the radio frame number change only where an inner count wraps;
- the radio frame pulse never fires without the hyperframe pulse, and the hyperframe pulse lasts one cycle;
- one cycle after each rising edge of sync, the counts are zero and the frame number holds the reload value.

Other behaviour can only be shown by the bench's scenarios:
- the exact wrap point for each of the ten rate codes tried;
- the deferral of a rate change until the basic frame in progress has ended;
- the handover from the last word of a radio frame to the first word of the next, including the frame number going from 4095 to 0;
- no resync while sync is held high.

// File: rtl/frame_pos_pkg.sv
package frame_pos_pkg;
  localparam int RATE_W   = 4;
  localparam int WORD_W   = 7;
  localparam int BF_COUNT = 256;
  localparam int HF_COUNT = 150;
  localparam int RF_W     = 12;
  localparam int BF_W     = $clog2(BF_COUNT);
  localparam int HF_W     = $clog2(HF_COUNT);

  // last word index of a basic frame for each rate code
  function automatic logic [WORD_W-1:0] last_word(input logic [RATE_W-1:0] code);
    logic [WORD_W-1:0] r;
    case (code)
      4'd0:    r = WORD_W'(3);
      4'd1:    r = WORD_W'(7);
      4'd2:    r = WORD_W'(15);
      4'd3:    r = WORD_W'(19);
      4'd4:    r = WORD_W'(31);
      4'd5:    r = WORD_W'(39);
      4'd6:    r = WORD_W'(63);
      4'd7:    r = WORD_W'(63);
      4'd8:    r = WORD_W'(79);
      default: r = WORD_W'(3);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sync_rise_det.sv
module sync_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic rise_o
);
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= sync_i;
  end

  assign rise_o = sync_i & ~sync_q;
endmodule

// File: rtl/word_counter.sv
module word_counter
  import frame_pos_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  output logic [WORD_W-1:0] word_o,
  output logic              wrap_o
);
  logic [WORD_W-1:0] word_q;
  logic [RATE_W-1:0] rate_q;
  logic              at_last;

  assign at_last = (word_q == last_word(rate_q));

  // rate is sampled only at a frame boundary or on resync
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      rate_q <= '0;
    end else if (clr_i || at_last) begin
      word_q <= '0;
      rate_q <= rate_sel_i;
    end else begin
      word_q <= word_q + WORD_W'(1);
    end
  end

  assign word_o = word_q;
  assign wrap_o = at_last & ~clr_i;
endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
  parameter int WIDTH = 8,
  parameter int COUNT = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(COUNT - 1);

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= load_val_i;
    else if (inc_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + WIDTH'(1);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i & (cnt_q == LAST);
endmodule

// File: rtl/frame_pos_counter.sv
module frame_pos_counter
  import frame_pos_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              sync_i,
  input  logic [RF_W-1:0]   reload_i,
  output logic [WORD_W-1:0] word_idx_o,
  output logic [BF_W-1:0]   bf_idx_o,
  output logic [HF_W-1:0]   hf_idx_o,
  output logic [RF_W-1:0]   rf_num_o,
  output logic              hf_pulse_o,
  output logic              rf_pulse_o
);
  logic resync;
  logic word_wrap, bf_wrap, hf_wrap, rf_wrap;

  sync_rise_det u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .rise_o (resync)
  );

  word_counter u_word (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (resync),
    .rate_sel_i (rate_sel_i),
    .word_o     (word_idx_o),
    .wrap_o     (word_wrap)
  );

  wrap_counter #(.WIDTH(BF_W), .COUNT(BF_COUNT)) u_bf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (resync),
    .load_val_i ('0),
    .inc_i      (word_wrap),
    .cnt_o      (bf_idx_o),
    .wrap_o     (bf_wrap)
  );

  wrap_counter #(.WIDTH(HF_W), .COUNT(HF_COUNT)) u_hf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (resync),
    .load_val_i ('0),
    .inc_i      (bf_wrap),
    .cnt_o      (hf_idx_o),
    .wrap_o     (hf_wrap)
  );

  wrap_counter #(.WIDTH(RF_W), .COUNT(1 << RF_W)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (resync),
    .load_val_i (reload_i),
    .inc_i      (hf_wrap),
    .cnt_o      (rf_num_o),
    .wrap_o     (rf_wrap)
  );

  logic unused_rf_wrap;
  assign unused_rf_wrap = rf_wrap;

  assign hf_pulse_o = (word_idx_o == '0) && (bf_idx_o == '0);
  assign rf_pulse_o = hf_pulse_o && (hf_idx_o == '0);
endmodule

// File: rtl/frame_pos_checker.sv
module frame_pos_checker
  import frame_pos_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [RATE_W-1:0] rate_sel_i,
  input logic              sync_i,
  input logic [RF_W-1:0]   reload_i,
  input logic [WORD_W-1:0] word_idx_o,
  input logic [BF_W-1:0]   bf_idx_o,
  input logic [HF_W-1:0]   hf_idx_o,
  input logic [RF_W-1:0]   rf_num_o,
  input logic              hf_pulse_o,
  input logic              rf_pulse_o
);
  logic sync_seen_q;
  logic edge_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_seen_q <= 1'b0;
    else         sync_seen_q <= sync_i;
  end
  assign edge_c = sync_i && !sync_seen_q;

  logic [RATE_W-1:0] unused_rate;
  assign unused_rate = rate_sel_i;

  a_r2_word_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_idx_o <= WORD_W'(79));

  a_r4_bf_steps_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_c |=> (word_idx_o == '0) || $stable(bf_idx_o));

  a_r5_hf_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hf_idx_o < HF_W'(HF_COUNT));

  a_r6_rf_steps_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_c |=> (hf_idx_o == '0) || $stable(rf_num_o));

  a_r7_hf_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hf_pulse_o && !edge_c) |=> !hf_pulse_o);

  a_r8_rf_implies_hf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_pulse_o |-> hf_pulse_o);

  a_r9_resync_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_c |=> (word_idx_o == '0) && (bf_idx_o == '0) && (hf_idx_o == '0)
               && (rf_num_o == $past(reload_i)) && rf_pulse_o);
endmodule

bind frame_pos_counter frame_pos_checker u_chk (.*);

// File: tb/sim_frame_pos_counter.sv
module sim_frame_pos_counter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  rate_sel_i = 4'd0;
  logic        sync_i = 1'b0;
  logic [11:0] reload_i = 12'd0;
  logic [6:0]  word_idx_o;
  logic [7:0]  bf_idx_o;
  logic [7:0]  hf_idx_o;
  logic [11:0] rf_num_o;
  logic        hf_pulse_o;
  logic        rf_pulse_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  frame_pos_counter u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic int last_of(input int code);
    case (code)
      0: return 3;   1: return 7;   2: return 15;  3: return 19;
      4: return 31;  5: return 39;  6: return 63;  7: return 63;
      8: return 79;  default: return 3;
    endcase
  endfunction

  // R9: rising edge, then check the zeroed position one clock later; sync stays high
  task automatic resync(input int code, input int rl);
    sync_i = 1'b0;
    wait_n(1);
    rate_sel_i = 4'(code);
    reload_i   = 12'(rl);
    sync_i     = 1'b1;
    wait_n(1);
    chk("R9 word", int'(word_idx_o), 0);
    chk("R9 bf", int'(bf_idx_o), 0);
    chk("R9 hf", int'(hf_idx_o), 0);
    chk("R9 rf", int'(rf_num_o), rl);
    chk("R9 pulses", int'({hf_pulse_o, rf_pulse_o}), 3);
  endtask

  task automatic t_reset;
    rate_sel_i = 4'd5;
    wait_n(2);
    chk("R1 word", int'(word_idx_o), 0);
    chk("R1 bf", int'(bf_idx_o), 0);
    chk("R1 hf", int'(hf_idx_o), 0);
    chk("R1 rf", int'(rf_num_o), 0);
    rst_ni = 1'b1;
    wait_n(3);
    chk("R1 word at code0 last", int'(word_idx_o), 3);
    wait_n(1);
    chk("R3 boundary word", int'(word_idx_o), 0);
    chk("R4 bf step", int'(bf_idx_o), 1);
    wait_n(39);
    chk("R3 new rate last", int'(word_idx_o), 39);
    wait_n(1);
    chk("R3 new rate wrap bf", int'(bf_idx_o), 2);
  endtask

  task automatic t_rates;
    for (int c = 0; c < 13; c++) begin
      if (c > 8 && c != 12) continue;
      resync(c, 0);
      sync_i = 1'b0;
      wait_n(last_of(c));
      chk($sformatf("R2 code %0d last", c), int'(word_idx_o), last_of(c));
      chk("R2 bf before wrap", int'(bf_idx_o), 0);
      wait_n(1);
      chk($sformatf("R2 code %0d wrap", c), int'(word_idx_o), 0);
      chk("R4 bf after wrap", int'(bf_idx_o), 1);
    end
  endtask

  task automatic t_rate_change;
    resync(0, 0);
    rate_sel_i = 4'd3;
    wait_n(3);
    chk("R3 old rate kept", int'(word_idx_o), 3);
    wait_n(1);
    chk("R3 boundary", int'(bf_idx_o), 1);
    wait_n(19);
    chk("R3 new rate word", int'(word_idx_o), 19);
    chk("R3 new rate bf", int'(bf_idx_o), 1);
    wait_n(1);
    chk("R3 new rate wrap", int'(bf_idx_o), 2);
    rate_sel_i = 4'd0;
  endtask

  task automatic t_hyper;
    resync(0, 7);
    sync_i = 1'b0;
    wait_n(1);
    chk("R7 pulse off", int'(hf_pulse_o), 0);
    wait_n(1022);
    chk("R4 bf top", int'(bf_idx_o), 255);
    chk("R7 no pulse", int'(hf_pulse_o), 0);
    wait_n(1);
    chk("R4 bf wrap", int'(bf_idx_o), 0);
    chk("R5 hf step", int'(hf_idx_o), 1);
    chk("R7 hf pulse", int'(hf_pulse_o), 1);
    chk("R8 no rf pulse", int'(rf_pulse_o), 0);
    chk("R6 rf held", int'(rf_num_o), 7);
  endtask

  task automatic t_hold;
    resync(0, 9);
    reload_i = 12'd55;
    wait_n(6);
    chk("R10 word runs", int'(word_idx_o), 2);
    chk("R10 bf runs", int'(bf_idx_o), 1);
    chk("R10 reload ignored", int'(rf_num_o), 9);
    sync_i = 1'b0;
    wait_n(1);
    chk("R10 fall no effect", int'(word_idx_o), 3);
  endtask

  task automatic t_rf_wrap;
    resync(0, 4095);
    sync_i = 1'b0;
    wait_n(153599);
    chk("R5 hf top", int'(hf_idx_o), 149);
    chk("R4 bf top", int'(bf_idx_o), 255);
    chk("R2 word top", int'(word_idx_o), 3);
    chk("R8 rf pulse off", int'(rf_pulse_o), 0);
    chk("R6 rf before", int'(rf_num_o), 4095);
    wait_n(1);
    chk("R5 hf wrap", int'(hf_idx_o), 0);
    chk("R6 rf wrap", int'(rf_num_o), 0);
    chk("R8 rf pulse", int'(rf_pulse_o), 1);
    chk("R7 hf pulse", int'(hf_pulse_o), 1);
  endtask

  initial begin
    t_reset();
    t_rates();
    t_rate_change();
    t_hyper();
    t_hold();
    t_rf_wrap();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule